// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block walks an integer-mode PLL through a safe change of its divider settings by acting as a master on a small bank of four 32-bit control words. A single start pulse captures the requested reference divider, feedback divider and two post-divider values. The block first checks them against the legal frequency and divider ranges, using a fixed reference frequency. A request outside those ranges is rejected before any control word is touched.

A legal request produces a fixed sequence of masked writes. The PLL is first parked in slow (bypass) mode. Integer mode is then selected, the feedback divider is loaded, and the reference and post-dividers are loaded. The status word is then polled until the lock bit reads 1, and only then is the PLL returned to normal mode. If lock does not arrive within a parameterised number of cycles, the block stops with an error and leaves the PLL in slow mode.

Every write carries a 16-bit write-enable mask in its upper half-word and the field data in its lower half-word. The mask enables only the bits of the field being changed. Reads of the status word return their data one cycle after the read strobe.

Top module: `pll_prog_seq`

## Requirements
- R1: After reset, busy_o, done_o, err_o, wr_en_o and rd_en_o are all 0.
- R2: A request is accepted only if refdiv, postdiv1 and postdiv2 are non-zero, fbdiv lies in 16..3200, the VCO frequency 24*fbdiv/refdiv MHz (exact) lies in 800..3200, and the output frequency VCO/(postdiv1*postdiv2) lies in 16..3200. A rejected request produces done_o with err_o = 1 and raises no wr_en_o or rd_en_o strobe.
- R3: For an accepted request, the writes come in exactly this order: word 3 slow mode, word 1 integer mode, word 0 feedback divider, word 1 dividers. Polling follows. The word 3 normal-mode write is issued only after a status read has returned lock = 1.
- R4: Write data holds the mask in [31:16] and the value in [15:0], and no value bit is set outside the mask. Word 0: fbdiv in [11:0], mask 0x0FFF. Word 1 integer mode: bit 15 = 1, mask 0x8000. Word 1 dividers: refdiv [5:0], postdiv1 [10:8], postdiv2 [14:12], mask 0x773F. Word 3 mode field [9:8]: slow = 0, normal = 1, mask 0x0300.
- R5: Polling raises rd_en_o with rd_addr_o = 2. The data on rd_data_i in the following cycle is examined, and bit 31 is the lock flag.
- R6: If lock has not been read within LOCK_TIMEOUT cycles of polling, the block finishes with done_o and err_o = 1 and issues no normal-mode write, so the mode field stays slow.
- R7: done_o is a single-cycle pulse issued while busy_o is low. err_o is valid with done_o and holds its value until the next accepted start.
- R8: A start pulse while busy_o is high is ignored, and the running sequence writes the values captured at its own start.
- R9: wr_en_o and rd_en_o are never high in the same cycle, and no write targets word 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request pulse |
| refdiv_i | input | 6 | Requested reference divider |
| fbdiv_i | input | 12 | Requested feedback divider |
| pdiv1_i | input | 3 | Requested first post-divider |
| pdiv2_i | input | 3 | Requested second post-divider |
| wr_en_o | output | 1 | Control word write strobe |
| wr_addr_o | output | 2 | Control word index for the write |
| wr_data_o | output | 32 | Write mask [31:16] and value [15:0] |
| rd_en_o | output | 1 | Status read strobe |
| rd_addr_o | output | 2 | Control word index for the read |
| rd_data_i | input | 32 | Read data, valid the cycle after rd_en_o |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Range or lock-timeout error |

## Verification
The assertions check properties that hold on every cycle. They cover strobe exclusivity, the read address, write words whose value bits stay inside their mask, the shape of the done pulse, err_o staying steady while idle, and the normal-mode write always following a status read. Only the bench's scenarios can show whether a given divider set is accepted or rejected. The same holds for the exact order and contents of the write sequence, the timeout path that leaves the mode field slow, and a start request that is ignored while a sequence runs.

// File: rtl/pll_prog_pkg.sv
package pll_prog_pkg;

    localparam int WORD_W    = 32;
    localparam int ADDR_W    = 2;
    localparam int REFDIV_W  = 6;
    localparam int FBDIV_W   = 12;
    localparam int PDIV_W    = 3;
    localparam int LOCK_BIT  = 31;

    localparam logic [ADDR_W-1:0] ADDR_FB   = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_DIV  = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd2;
    localparam logic [ADDR_W-1:0] ADDR_MODE = 2'd3;

    localparam logic [15:0] MASK_FB    = 16'h0FFF;
    localparam logic [15:0] MASK_INT   = 16'h8000;
    localparam logic [15:0] MASK_DIV   = 16'h773F;
    localparam logic [15:0] MASK_MODE  = 16'h0300;
    localparam logic [1:0]  MODE_SLOW  = 2'd0;
    localparam logic [1:0]  MODE_NORM  = 2'd1;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CHECK,
        S_SLOW,
        S_INTMODE,
        S_FBDIV,
        S_DIVS,
        S_POLL_RD,
        S_POLL_CHK,
        S_NORMAL
    } seq_state_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_SLOW,
        OP_INT,
        OP_FB,
        OP_DIV,
        OP_NORM
    } wr_op_e;

    typedef struct packed {
        seq_state_e           st;
        logic [REFDIV_W-1:0]  refdiv;
        logic [FBDIV_W-1:0]   fbdiv;
        logic [PDIV_W-1:0]    pd1;
        logic [PDIV_W-1:0]    pd2;
        logic                 done;
        logic                 err;
    } seq_regs_t;

endpackage

// File: rtl/pll_range_chk.sv
module pll_range_chk
    import pll_prog_pkg::*;
#(
    parameter int REF_MHZ     = 24,
    parameter int VCO_MIN_MHZ = 800,
    parameter int VCO_MAX_MHZ = 3200,
    parameter int OUT_MIN_MHZ = 16,
    parameter int OUT_MAX_MHZ = 3200,
    parameter int FB_MIN      = 16,
    parameter int FB_MAX      = 3200
) (
    input  logic [REFDIV_W-1:0] refdiv_i,
    input  logic [FBDIV_W-1:0]  fbdiv_i,
    input  logic [PDIV_W-1:0]   pd1_i,
    input  logic [PDIV_W-1:0]   pd2_i,
    output logic                ok_o
);
    localparam logic [31:0] REF_C    = 32'(REF_MHZ);
    localparam logic [31:0] VMIN_C   = 32'(VCO_MIN_MHZ);
    localparam logic [31:0] VMAX_C   = 32'(VCO_MAX_MHZ);
    localparam logic [31:0] OMIN_C   = 32'(OUT_MIN_MHZ);
    localparam logic [31:0] OMAX_C   = 32'(OUT_MAX_MHZ);
    localparam logic [31:0] FBMIN_C  = 32'(FB_MIN);
    localparam logic [31:0] FBMAX_C  = 32'(FB_MAX);

    logic [31:0] ref_w, fb_w, post_w, vco_scaled, div_total;
    logic        nz_ok, fb_ok, vco_lo_ok, vco_hi_ok, out_lo_ok, out_hi_ok;

    // Frequencies are compared cross-multiplied, so no divider is needed
    always_comb begin
        ref_w      = 32'(refdiv_i);
        fb_w       = 32'(fbdiv_i);
        post_w     = 32'(pd1_i) * 32'(pd2_i);
        vco_scaled = REF_C * fb_w;
        div_total  = ref_w * post_w;
        nz_ok      = (refdiv_i != '0) && (pd1_i != '0) && (pd2_i != '0);
        fb_ok      = (fb_w >= FBMIN_C) && (fb_w <= FBMAX_C);
        vco_lo_ok  = vco_scaled >= VMIN_C * ref_w;
        vco_hi_ok  = vco_scaled <= VMAX_C * ref_w;
        out_lo_ok  = vco_scaled >= OMIN_C * div_total;
    end

    // The output ceiling only needs its own comparator when it is tighter than the VCO ceiling
    generate
        if (OUT_MAX_MHZ < VCO_MAX_MHZ) begin : g_out_hi
            assign out_hi_ok = vco_scaled <= OMAX_C * div_total;
        end else begin : g_out_hi_implied
            assign out_hi_ok = 1'b1;
        end
    endgenerate

    assign ok_o = nz_ok && fb_ok && vco_lo_ok && vco_hi_ok && out_lo_ok && out_hi_ok;

endmodule

// File: rtl/pll_lock_timer.sv
module pll_lock_timer #(
    parameter int LIMIT = 50000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clr_i,
    input  logic en_i,
    output logic expired_o
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIMIT_C = CW'(LIMIT);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (en_i && (cnt_q != LIMIT_C)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired_o = (cnt_q == LIMIT_C);

endmodule

// File: rtl/pll_word_fmt.sv
module pll_word_fmt
    import pll_prog_pkg::*;
(
    input  wr_op_e              op_i,
    input  logic [REFDIV_W-1:0] refdiv_i,
    input  logic [FBDIV_W-1:0]  fbdiv_i,
    input  logic [PDIV_W-1:0]   pd1_i,
    input  logic [PDIV_W-1:0]   pd2_i,
    output logic                wr_en_o,
    output logic [ADDR_W-1:0]   wr_addr_o,
    output logic [WORD_W-1:0]   wr_data_o
);
    logic [15:0] mask, val;

    always_comb begin
        wr_en_o   = 1'b1;
        wr_addr_o = ADDR_MODE;
        mask      = '0;
        val       = '0;
        unique case (op_i)
            OP_SLOW: begin
                wr_addr_o = ADDR_MODE;
                mask      = MASK_MODE;
                val[9:8]  = MODE_SLOW;
            end
            OP_INT: begin
                wr_addr_o = ADDR_DIV;
                mask      = MASK_INT;
                val[15]   = 1'b1;
            end
            OP_FB: begin
                wr_addr_o = ADDR_FB;
                mask      = MASK_FB;
                val[11:0] = fbdiv_i;
            end
            OP_DIV: begin
                wr_addr_o   = ADDR_DIV;
                mask        = MASK_DIV;
                val[5:0]    = refdiv_i;
                val[10:8]   = pd1_i;
                val[14:12]  = pd2_i;
            end
            OP_NORM: begin
                wr_addr_o = ADDR_MODE;
                mask      = MASK_MODE;
                val[9:8]  = MODE_NORM;
            end
            default: begin
                wr_en_o = 1'b0;
            end
        endcase
        wr_data_o = {mask, val & mask};
    end

endmodule

// File: rtl/pll_prog_seq.sv
module pll_prog_seq
    import pll_prog_pkg::*;
#(
    parameter int REF_MHZ      = 24,
    parameter int VCO_MIN_MHZ  = 800,
    parameter int VCO_MAX_MHZ  = 3200,
    parameter int OUT_MIN_MHZ  = 16,
    parameter int OUT_MAX_MHZ  = 3200,
    parameter int FB_MIN       = 16,
    parameter int FB_MAX       = 3200,
    parameter int LOCK_TIMEOUT = 50000
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                start_i,
    input  logic [5:0]          refdiv_i,
    input  logic [11:0]         fbdiv_i,
    input  logic [2:0]          pdiv1_i,
    input  logic [2:0]          pdiv2_i,
    output logic                wr_en_o,
    output logic [1:0]          wr_addr_o,
    output logic [31:0]         wr_data_o,
    output logic                rd_en_o,
    output logic [1:0]          rd_addr_o,
    input  logic [31:0]         rd_data_i,
    output logic                busy_o,
    output logic                done_o,
    output logic                err_o
);
    seq_regs_t r_d, r_q;
    wr_op_e    op;
    logic      range_ok, timer_clr, timer_en, timer_expired, rd_en;

    pll_range_chk #(
        .REF_MHZ    (REF_MHZ),
        .VCO_MIN_MHZ(VCO_MIN_MHZ),
        .VCO_MAX_MHZ(VCO_MAX_MHZ),
        .OUT_MIN_MHZ(OUT_MIN_MHZ),
        .OUT_MAX_MHZ(OUT_MAX_MHZ),
        .FB_MIN     (FB_MIN),
        .FB_MAX     (FB_MAX)
    ) i_range (
        .refdiv_i(r_q.refdiv),
        .fbdiv_i (r_q.fbdiv),
        .pd1_i   (r_q.pd1),
        .pd2_i   (r_q.pd2),
        .ok_o    (range_ok)
    );

    pll_lock_timer #(
        .LIMIT(LOCK_TIMEOUT)
    ) i_timer (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .clr_i    (timer_clr),
        .en_i     (timer_en),
        .expired_o(timer_expired)
    );

    pll_word_fmt i_fmt (
        .op_i     (op),
        .refdiv_i (r_q.refdiv),
        .fbdiv_i  (r_q.fbdiv),
        .pd1_i    (r_q.pd1),
        .pd2_i    (r_q.pd2),
        .wr_en_o  (wr_en_o),
        .wr_addr_o(wr_addr_o),
        .wr_data_o(wr_data_o)
    );

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        op        = OP_NONE;
        rd_en     = 1'b0;
        timer_clr = 1'b0;
        timer_en  = 1'b0;
        unique case (r_q.st)
            S_IDLE: begin
                if (start_i) begin
                    r_d.refdiv = refdiv_i;
                    r_d.fbdiv  = fbdiv_i;
                    r_d.pd1    = pdiv1_i;
                    r_d.pd2    = pdiv2_i;
                    r_d.err    = 1'b0;
                    r_d.st     = S_CHECK;
                end
            end
            S_CHECK: begin
                timer_clr = 1'b1;
                if (range_ok) begin
                    r_d.st = S_SLOW;
                end else begin
                    r_d.st   = S_IDLE;
                    r_d.done = 1'b1;
                    r_d.err  = 1'b1;
                end
            end
            S_SLOW: begin
                op     = OP_SLOW;
                r_d.st = S_INTMODE;
            end
            S_INTMODE: begin
                op     = OP_INT;
                r_d.st = S_FBDIV;
            end
            S_FBDIV: begin
                op     = OP_FB;
                r_d.st = S_DIVS;
            end
            S_DIVS: begin
                op        = OP_DIV;
                timer_clr = 1'b1;
                r_d.st    = S_POLL_RD;
            end
            S_POLL_RD: begin
                rd_en    = 1'b1;
                timer_en = 1'b1;
                r_d.st   = S_POLL_CHK;
            end
            S_POLL_CHK: begin
                timer_en = 1'b1;
                if (rd_data_i[LOCK_BIT]) begin
                    r_d.st = S_NORMAL;
                end else if (timer_expired) begin
                    r_d.st   = S_IDLE;
                    r_d.done = 1'b1;
                    r_d.err  = 1'b1;
                end else begin
                    r_d.st = S_POLL_RD;
                end
            end
            S_NORMAL: begin
                op       = OP_NORM;
                r_d.st   = S_IDLE;
                r_d.done = 1'b1;
            end
            default: begin
                r_d.st = S_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '{st: S_IDLE, refdiv: '0, fbdiv: '0, pd1: '0, pd2: '0,
                     done: 1'b0, err: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_en_o   = rd_en;
    assign rd_addr_o = ADDR_STAT;
    assign busy_o    = (r_q.st != S_IDLE);
    assign done_o    = r_q.done;
    assign err_o     = r_q.err;

endmodule

// File: rtl/pll_prog_seq_chk.sv
module pll_prog_seq_chk (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        busy_o,
    input logic        done_o,
    input logic        err_o,
    input logic        wr_en_o,
    input logic [1:0]  wr_addr_o,
    input logic [31:0] wr_data_o,
    input logic        rd_en_o,
    input logic [1:0]  rd_addr_o
);
    AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(wr_en_o && rd_en_o)); // R9

    AST_NO_STATUS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_o |-> (wr_addr_o != 2'd2)); // R9

    AST_READ_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_en_o |-> (rd_addr_o == 2'd2)); // R5

    AST_VALUE_IN_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_o |-> (((wr_data_o[15:0] & ~wr_data_o[31:16]) == 16'h0) && (wr_data_o[31:16] != 16'h0))); // R4

    AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o); // R7

    AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !busy_o); // R7

    AST_ERR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && !done_o) |=> (busy_o || $stable(err_o))); // R7

    AST_NORMAL_AFTER_POLL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_o && (wr_addr_o == 2'd3) && (wr_data_o[9:8] == 2'd1)) |-> $past(rd_en_o, 2)); // R3

    AST_NO_WRITE_ON_CHECK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> !wr_en_o); // R2

endmodule

bind pll_prog_seq pll_prog_seq_chk i_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .err_o    (err_o),
    .wr_en_o  (wr_en_o),
    .wr_addr_o(wr_addr_o),
    .wr_data_o(wr_data_o),
    .rd_en_o  (rd_en_o),
    .rd_addr_o(rd_addr_o)
);

// File: tb/test_pll_prog_seq.sv
module test_pll_prog_seq;

    localparam int TIMEOUT_CYC = 40;
    localparam int NVEC = 14;

    // {refdiv[6], fbdiv[12], pd1[3], pd2[3], lock delay[8], outcome[2]} outcome: 0 ok, 1 reject, 2 timeout
    localparam logic [33:0] VEC [NVEC] = '{
        {6'd1,  12'd50,   3'd3, 3'd2, 8'd3,   2'd0},
        {6'd2,  12'd100,  3'd4, 3'd1, 8'd10,  2'd0},
        {6'd1,  12'd63,   3'd1, 3'd1, 8'd0,   2'd0},
        {6'd1,  12'd200,  3'd1, 3'd1, 8'd0,   2'd1},
        {6'd1,  12'd33,   3'd1, 3'd1, 8'd0,   2'd1},
        {6'd3,  12'd100,  3'd7, 3'd7, 8'd5,   2'd0},
        {6'd63, 12'd3201, 3'd1, 3'd1, 8'd0,   2'd1},
        {6'd63, 12'd3200, 3'd1, 3'd1, 8'd2,   2'd0},
        {6'd0,  12'd50,   3'd1, 3'd1, 8'd0,   2'd1},
        {6'd1,  12'd50,   3'd0, 3'd1, 8'd0,   2'd1},
        {6'd1,  12'd133,  3'd2, 3'd2, 8'd4,   2'd0},
        {6'd1,  12'd134,  3'd2, 3'd2, 8'd4,   2'd1},
        {6'd3,  12'd400,  3'd1, 3'd1, 8'd1,   2'd0},
        {6'd1,  12'd50,   3'd2, 3'd1, 8'd200, 2'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [5:0]  refdiv = '0;
    logic [11:0] fbdiv = '0;
    logic [2:0]  pd1 = '0, pd2 = '0;
    logic        wr_en, rd_en, busy, done, err;
    logic [1:0]  wr_addr, rd_addr;
    logic [31:0] wr_data;
    logic [31:0] rd_data = '0;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;

    // Control word model and write log
    logic [15:0] regs [4];
    logic [1:0]  log_a [16];
    logic [31:0] log_d [16];
    int          n_log = 0;
    int          n_rd = 0;
    int          lock_dly = 0;
    int          lock_cnt = 0;
    logic        locking = 1'b0;
    logic        lock_at_norm = 1'b0;
    logic        lock_now;

    always #4 clk = ~clk;

    pll_prog_seq #(.LOCK_TIMEOUT(TIMEOUT_CYC)) i_pll_prog_seq (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start),
        .refdiv_i(refdiv), .fbdiv_i(fbdiv), .pdiv1_i(pd1), .pdiv2_i(pd2),
        .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
        .rd_en_o(rd_en), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
        .busy_o(busy), .done_o(done), .err_o(err)
    );

    assign lock_now = locking && (lock_cnt >= lock_dly);

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (rst_n) begin
            if (locking && lock_cnt < lock_dly) lock_cnt <= lock_cnt + 1;
            if (rd_en) begin
                rd_data <= {lock_now, 15'h0, regs[rd_addr]};
                n_rd <= n_rd + 1;
            end
            if (wr_en) begin
                regs[wr_addr] <= (regs[wr_addr] & ~wr_data[31:16]) | (wr_data[15:0] & wr_data[31:16]);
                if (n_log < 16) begin
                    log_a[n_log] <= wr_addr;
                    log_d[n_log] <= wr_data;
                end
                n_log <= n_log + 1;
                if (wr_addr == 2'd0 || (wr_addr == 2'd1 && wr_data[31:16] != 16'h8000)) begin
                    locking  <= 1'b1;
                    lock_cnt <= 0;
                end
                if (wr_addr == 2'd3 && wr_data[9:8] == 2'd1) lock_at_norm <= lock_now;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic clear_log(input int dly);
        @(negedge clk);
        n_log = 0;
        n_rd = 0;
        lock_dly = dly;
        locking = 1'b0;
        lock_cnt = 0;
        lock_at_norm = 1'b0;
    endtask

    task automatic pulse_start(input logic [5:0] r, input logic [11:0] f, input logic [2:0] a, input logic [2:0] b);
        refdiv = r; fbdiv = f; pd1 = a; pd2 = b;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output bit got);
        got = 1'b0;
        for (int i = 0; i < 2000; i++) begin
            if (done) begin
                got = 1'b1;
                break;
            end
            @(negedge clk);
        end
    endtask

    // Compares the write log against the sequence the requirements define
    task automatic check_log(input logic [5:0] r, input logic [11:0] f, input logic [2:0] a,
                             input logic [2:0] b, input int nexp);
        logic [31:0] exp_d [5];
        logic [1:0]  exp_a [5];
        exp_a[0] = 2'd3; exp_d[0] = 32'h0300_0000;
        exp_a[1] = 2'd1; exp_d[1] = 32'h8000_8000;
        exp_a[2] = 2'd0; exp_d[2] = {16'h0FFF, 4'h0, f};
        exp_a[3] = 2'd1; exp_d[3] = {16'h773F, 1'b0, b, 1'b0, a, 2'b00, r};
        exp_a[4] = 2'd3; exp_d[4] = 32'h0300_0100;
        chk(n_log == nexp, "R3 write count", 32'(n_log), 32'(nexp));
        for (int k = 0; k < nexp && k < n_log; k++) begin
            chk(log_a[k] == exp_a[k], "R3 write order", 32'(log_a[k]), 32'(exp_a[k]));
            chk(log_d[k] == exp_d[k], "R4 write data", log_d[k], exp_d[k]);
        end
    endtask

    initial begin
        bit got;
        regs[0] = '0; regs[1] = '0; regs[2] = '0; regs[3] = 16'h0100;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!busy && !done && !err && !wr_en && !rd_en, "R1 reset outputs",
            {27'h0, busy, done, err, wr_en, rd_en}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !err, "R1 idle after reset", {29'h0, busy, done, err}, 32'h0);

        for (int v = 0; v < NVEC; v++) begin
            logic [5:0]  r;
            logic [11:0] f;
            logic [2:0]  a, b;
            logic [7:0]  d;
            logic [1:0]  oc;
            {r, f, a, b, d, oc} = VEC[v];
            clear_log(int'(d));
            pulse_start(r, f, a, b);
            wait_done(got);
            chk(got, "R7 done seen", 32'(got), 32'd1);
            chk(err == (oc != 2'd0), (oc == 2'd1) ? "R2 range error" : (oc == 2'd2) ? "R6 timeout error" : "R2 accepted",
                32'(err), 32'(oc != 2'd0));
            if (oc == 2'd1) begin
                chk(n_log == 0 && n_rd == 0, "R2 no strobes on reject", 32'(n_log + n_rd), 32'd0);
            end else if (oc == 2'd2) begin
                check_log(r, f, a, b, 4);
                chk(regs[3][9:8] == 2'd0, "R6 mode stays slow", 32'(regs[3][9:8]), 32'd0);
                chk(n_rd >= TIMEOUT_CYC / 2, "R5 polling continued", 32'(n_rd), 32'(TIMEOUT_CYC / 2));
            end else begin
                check_log(r, f, a, b, 5);
                chk(lock_at_norm, "R3 normal only after lock", 32'(lock_at_norm), 32'd1);
                chk(n_rd >= 1, "R5 status polled", 32'(n_rd), 32'd1);
                chk(regs[3][9:8] == 2'd1, "R4 mode normal", 32'(regs[3][9:8]), 32'd1);
            end
            @(negedge clk);
            chk(!done, "R7 done single cycle", 32'(done), 32'd0);
        end

        // R7: error held while idle, cleared by next accepted start
        clear_log(0);
        pulse_start(6'd1, 12'd300, 3'd1, 3'd1);
        wait_done(got);
        repeat (6) @(negedge clk);
        chk(err && !done && !busy, "R7 err held idle", {29'h0, err, done, busy}, 32'h4);
        pulse_start(6'd1, 12'd50, 3'd3, 3'd2);
        chk(!err && busy, "R7 err cleared on start", {30'h0, err, busy}, 32'h1);
        wait_done(got);
        chk(!err, "R7 err low after good run", 32'(err), 32'd0);

        // R8: start while busy ignored
        clear_log(6);
        pulse_start(6'd2, 12'd100, 3'd2, 3'd1);
        @(negedge clk);
        pulse_start(6'd1, 12'd60, 3'd1, 3'd1);
        wait_done(got);
        check_log(6'd2, 12'd100, 3'd2, 3'd1, 5);
        repeat (4) @(negedge clk);
        chk(!busy && n_log == 5, "R8 second start ignored", 32'(n_log), 32'd5);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        wait (cycles > 100000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule